// File: doc/BRIEF.md
# Module Clock-Gating Power Sequencer

This block gates the clock of a single processor module under software control. Software picks a target state in a register and then writes a start bit. For a stop, the sequencer raises a clock-stop request interrupt toward the processor. It keeps the clock running until the processor shows it has gone idle (wait-for-interrupt). Only then does it drop the clock enable and report the new state. For an enable, it restarts the clock and releases the module reset. When the module comes back from the stopped state, a separate wake request is also needed to bring the processor out of its idle wait.

The sequencer is a four-state machine. `SQ_IDLE` waits for a start command. `SQ_STOP_WAIT` holds the stop request until idle is seen. `SQ_CLK_DROP` is the cycle in which the clock enable falls. `SQ_CLK_RAISE` is the cycle in which the clock enable rises. The named transitions are:

- start-stop: `SQ_IDLE` to `SQ_STOP_WAIT`, taken when the clock is running.
- start-stop-cold: `SQ_IDLE` to `SQ_CLK_DROP`, taken when the clock is already off.
- start-enable: `SQ_IDLE` to `SQ_CLK_RAISE`.
- idle-seen: `SQ_STOP_WAIT` to `SQ_CLK_DROP`.
- finish: `SQ_CLK_DROP` or `SQ_CLK_RAISE` back to `SQ_IDLE`.

Module state codes are: 0 for held in reset with the clock off, 2 for stopped, and 3 for running.

Top module: `clkgate_seq`

## Requirements
- R1: After reset, `clk_en`=0, `stop_req`=0, `mod_rst_n`=0, `wake_pulse`=0, the busy bit reads 0, the state field reads 0 and the target field reads 0.
- R2: The register map is as follows. Address 0 holds the 2-bit target field in bits [1:0], and it reads back whatever value was last written. Address 1 is the command register: a write with bit 0 set is a start. Address 2 bit 0 is the live busy flag. Address 3 bits [1:0] is the live state field. Target code 2 means stop and code 3 means run.
- R3: A start with target 3 sets busy and `clk_en` in the cycle after the write. One cycle later, busy reads 0, the state reads 3 and `mod_rst_n` is 1.
- R4: A start with target 2 while the clock runs raises `stop_req` and busy in the cycle after the write. Both stay high, and `clk_en` stays 1, for as long as `cpu_idle` is low.
- R5: The first cycle after `cpu_idle` is sampled high during the request, `clk_en` and `stop_req` both read 0 and busy is still 1. One cycle later, busy reads 0 and the state reads 2.
- R6: A start with target 2 while the clock is already off skips the request. `stop_req` stays 0 and `clk_en` stays 0. Busy reads 1 for one cycle, then the state reads 2, and `mod_rst_n` stays 0 if no run transition has ever completed.
- R7: A start written while busy is 1 is ignored. A target write during a transition is stored, but the transition in progress still ends in the state chosen at its start.
- R8: A start with target code 0 or 1 finishes at once. Busy never reads 1, and the state and `clk_en` are unchanged.
- R9: `clk_en` changes only in cycles where busy is 1, so it always moves one cycle before busy clears.
- R10: After a run transition that began from state 2 completes, the first cycle `wake_req` is sampled high produces exactly one `wake_pulse` cycle. A run transition that began from state 0 or state 3 does not arm the wake. `wake_req` has no effect while the wake is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cpu_idle | input | 1 | Processor signals wait-for-interrupt reached |
| wake_req | input | 1 | Wake request line |
| clk_en | output | 1 | Module clock enable |
| stop_req | output | 1 | Clock-stop request interrupt, level |
| mod_rst_n | output | 1 | Module reset, active low |
| wake_pulse | output | 1 | One-cycle wake interrupt to the processor |

## Verification
On every cycle, the assertions check four things:
- `clk_en` moves only while busy, and the clock runs whenever a stop request is pending.
- The stop request drops together with the clock enable.
- Reset release coincides with a running clock.
- A wake pulse never lasts two cycles.

Only the bench scenarios can show the rest:
- The exact cycle counts of the run and stop paths.
- The cold stop that skips the request.
- That a target written during a transition does not redirect it.
- That unsupported codes and unarmed wake requests leave every output untouched.

// File: rtl/clkgate_seq_pkg.sv
package clkgate_seq_pkg;
    typedef enum logic [1:0] {
        MS_SWRST   = 2'd0,
        MS_RSVD    = 2'd1,
        MS_DISABLE = 2'd2,
        MS_ENABLE  = 2'd3
    } mstate_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_STOP_WAIT,
        SQ_CLK_DROP,
        SQ_CLK_RAISE
    } seq_t;

    localparam int REG_TARGET = 0;
    localparam int REG_CMD    = 1;
    localparam int REG_BUSY   = 2;
    localparam int REG_MSTAT  = 3;
endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs
    import clkgate_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  mstate_t           mstate,
    output mstate_t           target,
    output logic              go
);
    localparam int CODE_W = $bits(mstate_t);

    logic [CODE_W-1:0] target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (bus_we && bus_addr == ADDR_W'(REG_TARGET)) begin
            target_q <= bus_wdata[CODE_W-1:0];
        end
    end

    assign target = mstate_t'(target_q);
    assign go     = bus_we && (bus_addr == ADDR_W'(REG_CMD)) && bus_wdata[0];

    always_comb begin
        bus_rdata = '0;
        unique case (int'(bus_addr))
            REG_TARGET: bus_rdata[CODE_W-1:0] = target_q;
            REG_BUSY:   bus_rdata[0]          = busy;
            REG_MSTAT:  bus_rdata[CODE_W-1:0] = mstate;
            default:    bus_rdata             = '0;
        endcase
    end
endmodule

// File: rtl/clkgate_fsm.sv
module clkgate_fsm
    import clkgate_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  mstate_t target,
    input  logic    cpu_idle,
    input  logic    wake_req,
    output logic    busy,
    output mstate_t mstate,
    output logic    clk_en,
    output logic    stop_req,
    output logic    mod_rst_n,
    output logic    wake_pulse
);
    seq_t    seq_q, seq_d;
    mstate_t mstate_q;
    logic    busy_q, clk_en_q, stop_q, rst_rel_q, armed_q, wake_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SQ_IDLE: begin
                if (go) begin
                    if (target == MS_DISABLE)
                        seq_d = clk_en_q ? SQ_STOP_WAIT : SQ_CLK_DROP;
                    else if (target == MS_ENABLE)
                        seq_d = SQ_CLK_RAISE;
                end
            end
            SQ_STOP_WAIT: if (cpu_idle) seq_d = SQ_CLK_DROP;
            SQ_CLK_DROP:  seq_d = SQ_IDLE;
            SQ_CLK_RAISE: seq_d = SQ_IDLE;
            default:      seq_d = SQ_IDLE;
        endcase
    end

    // state register and committed module state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= SQ_IDLE;
            mstate_q <= MS_SWRST;
        end else begin
            seq_q <= seq_d;
            if (seq_q == SQ_CLK_DROP)  mstate_q <= MS_DISABLE;
            if (seq_q == SQ_CLK_RAISE) mstate_q <= MS_ENABLE;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            clk_en_q  <= 1'b0;
            stop_q    <= 1'b0;
            rst_rel_q <= 1'b0;
            armed_q   <= 1'b0;
            wake_q    <= 1'b0;
        end else begin
            busy_q <= (seq_d != SQ_IDLE);
            stop_q <= (seq_d == SQ_STOP_WAIT);
            if (seq_d == SQ_CLK_DROP)  clk_en_q <= 1'b0;
            if (seq_d == SQ_CLK_RAISE) clk_en_q <= 1'b1;
            if (seq_q == SQ_CLK_RAISE) rst_rel_q <= 1'b1;
            wake_q <= armed_q && wake_req;
            if (seq_q == SQ_IDLE && seq_d != SQ_IDLE)
                armed_q <= 1'b0;
            else if (seq_q == SQ_CLK_RAISE && mstate_q == MS_DISABLE)
                armed_q <= 1'b1;
            else if (armed_q && wake_req)
                armed_q <= 1'b0;
        end
    end

    assign busy       = busy_q;
    assign mstate     = mstate_q;
    assign clk_en     = clk_en_q;
    assign stop_req   = stop_q;
    assign mod_rst_n  = rst_rel_q;
    assign wake_pulse = wake_q;

    // R9
    clk_en_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_en_q) |-> busy_q);
    // R4
    stop_clk_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> (clk_en_q && busy_q));
    // R5
    stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_q) |-> !clk_en_q);
    // R3
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_rel_q) |-> clk_en_q);
    // R10
    wake_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);
endmodule

// File: rtl/clkgate_seq.sv
module clkgate_seq
    import clkgate_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cpu_idle,
    input  logic              wake_req,
    output logic              clk_en,
    output logic              stop_req,
    output logic              mod_rst_n,
    output logic              wake_pulse
);
    logic    go, busy;
    mstate_t target, mstate;

    clkgate_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .mstate    (mstate),
        .target    (target),
        .go        (go)
    );

    clkgate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .target     (target),
        .cpu_idle   (cpu_idle),
        .wake_req   (wake_req),
        .busy       (busy),
        .mstate     (mstate),
        .clk_en     (clk_en),
        .stop_req   (stop_req),
        .mod_rst_n  (mod_rst_n),
        .wake_pulse (wake_pulse)
    );
endmodule

// File: tb/tb_clkgate_seq.sv
module tb_clkgate_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_idle = 1'b0;
    logic        wake_req = 1'b0;
    logic        clk_en, stop_req, mod_rst_n, wake_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    clkgate_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_idle(cpu_idle),
        .wake_req(wake_req), .clk_en(clk_en), .stop_req(stop_req),
        .mod_rst_n(mod_rst_n), .wake_pulse(wake_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // stimulus: we,addr,wdata,idle,wake | expected: clk_en,stop,busy,state,rst_n,wake
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1,2'd0,2'd3,1'b0,1'b0, 1'b0,1'b0,1'b0,2'd0,1'b0,1'b0}, // R2 target=3
        {1'b1,2'd1,2'd1,1'b0,1'b0, 1'b1,1'b0,1'b1,2'd0,1'b0,1'b0}, // R3 start run
        {1'b0,2'd0,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b0,2'd3,1'b1,1'b0}, // R3 done
        {1'b1,2'd0,2'd2,1'b0,1'b0, 1'b1,1'b0,1'b0,2'd3,1'b1,1'b0}, // R2 target=2
        {1'b1,2'd1,2'd1,1'b0,1'b0, 1'b1,1'b1,1'b1,2'd3,1'b1,1'b0}, // R4 request
        {1'b0,2'd0,2'd0,1'b0,1'b0, 1'b1,1'b1,1'b1,2'd3,1'b1,1'b0}, // R4 held
        {1'b1,2'd1,2'd1,1'b0,1'b0, 1'b1,1'b1,1'b1,2'd3,1'b1,1'b0}, // R7 start ignored
        {1'b0,2'd0,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b1,2'd3,1'b1,1'b0}, // R5 drop
        {1'b0,2'd0,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0,2'd2,1'b1,1'b0}, // R5 settled
        {1'b1,2'd0,2'd3,1'b0,1'b0, 1'b0,1'b0,1'b0,2'd2,1'b1,1'b0}, // R2
        {1'b1,2'd1,2'd1,1'b0,1'b0, 1'b1,1'b0,1'b1,2'd2,1'b1,1'b0}, // R9 raise while busy
        {1'b0,2'd0,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b0,2'd3,1'b1,1'b0}, // R3
        {1'b0,2'd0,2'd0,1'b0,1'b1, 1'b1,1'b0,1'b0,2'd3,1'b1,1'b1}, // R10 pulse
        {1'b0,2'd0,2'd0,1'b0,1'b1, 1'b1,1'b0,1'b0,2'd3,1'b1,1'b0}, // R10 single
        {1'b1,2'd0,2'd1,1'b0,1'b0, 1'b1,1'b0,1'b0,2'd3,1'b1,1'b0}, // R8 code 1
        {1'b1,2'd1,2'd1,1'b0,1'b0, 1'b1,1'b0,1'b0,2'd3,1'b1,1'b0}  // R8 no effect
    };

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic outs(input string req, input logic ce, input logic sr, input logic bz,
                        input logic [1:0] st, input logic rn, input logic wk);
        logic [31:0] v;
        check(req, "clk_en", {31'b0, clk_en}, {31'b0, ce});
        check(req, "stop_req", {31'b0, stop_req}, {31'b0, sr});
        check(req, "mod_rst_n", {31'b0, mod_rst_n}, {31'b0, rn});
        check(req, "wake_pulse", {31'b0, wake_pulse}, {31'b0, wk});
        rd(2'd2, v); check(req, "busy", v, {31'b0, bz});
        rd(2'd3, v); check(req, "state", v, {30'b0, st});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; cpu_idle = 1'b0; wake_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R1 reset state
        outs("R1", 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        rd(2'd0, v); check("R1", "target", v, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [13:0] e;
            e = VEC[i];
            bus_we = e[13]; bus_addr = e[12:11]; bus_wdata = {30'b0, e[10:9]};
            cpu_idle = e[8]; wake_req = e[7];
            tick();
            outs($sformatf("vec%0d", i), e[6], e[5], e[4], e[3:2], e[1], e[0]);
        end
        wake_req = 1'b0;
        // R2 / R8 unsupported code stored and read back
        rd(2'd0, v); check("R8", "target readback", v, 32'd1);

        // R7 target rewritten mid-transition does not redirect
        wr(2'd0, 32'd2);
        wr(2'd1, 32'd1);
        outs("R7", 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0);
        wr(2'd0, 32'd3);
        wr(2'd1, 32'd1);
        cpu_idle = 1'b1; tick(); cpu_idle = 1'b0;
        tick();
        outs("R7", 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0);
        rd(2'd0, v); check("R2", "target readback", v, 32'd3);

        // R6 cold stop straight from reset
        do_reset();
        wr(2'd0, 32'd2);
        wr(2'd1, 32'd1);
        outs("R6", 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
        tick();
        outs("R6", 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0);

        // R10 run from reset state does not arm the wake
        do_reset();
        wr(2'd0, 32'd3);
        wr(2'd1, 32'd1);
        tick();
        wake_req = 1'b1; tick();
        outs("R10", 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0);
        tick();
        outs("R10", 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0);
        wake_req = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule